// File: doc/BRIEF.md
# Inter-core mailbox array

The block holds a bank of 32-bit mailboxes, a fixed number per core, that cores use to signal each other and to hand a start address to a core that is being brought up. Each mailbox can be written through two addresses on a simple 32-bit register bus. A write to its set address ORs the written data into the mailbox. A write to its clear address removes the written ones from the mailbox.

A core that receives an interrupt reads its mailbox through the clear address. It picks the lowest set bit and writes that bit back to the same address to acknowledge it. A whole 32-bit word, such as a boot address, can also be placed in a mailbox with a single set write.

For every mailbox the block drives a level that stays high while any bit of that mailbox is set. The levels are grouped per core and go to a separate interrupt-routing stage. Enabling, masking and fast/normal interrupt selection belong to that stage and are not part of this block.

Top module: `core_mailbox`

## Requirements
- R1: After reset every mailbox is zero, `pend_o` is all zero and `rdata_o` is zero.
- R2: With byte address `a`, mailbox `m` of core `c` is set through `a = 0x080 + 16*c + 4*m` and cleared through `a = 0x0C0 + 16*c + 4*m`, and its level is `pend_o[4*c + m]`.
- R3: A write (`req_i=1`, `we_i=1`) to a set address ORs `wdata_i` into that mailbox at the clock edge and leaves every other mailbox unchanged.
- R4: A write to a clear address ANDs that mailbox with the inverse of `wdata_i` at the clock edge.
- R5: `pend_o[i]` is high exactly while mailbox `i` is non-zero, and it follows the mailbox in the cycle after the write edge.
- R6: A read (`req_i=1`, `we_i=0`) of a clear address returns that mailbox's contents on `rdata_o` in the cycle after the request edge.
- R7: A read of a set address, of an address outside both windows, or of an address with a non-zero `addr_i[1:0]`, returns zero. In any cycle that follows an edge without a read, `rdata_o` is zero.
- R8: Writes to addresses outside both windows, or with a non-zero `addr_i[1:0]`, change no mailbox.
- R9: A single set write to an empty mailbox stores all 32 bits of `wdata_i`, and a read of the clear address returns that value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| pend_o | output | 16 | Per-mailbox non-empty levels, index 4*core + mailbox |

## Verification
The bench builds the block with its default parameters: four cores, four mailboxes per core, 32-bit data and an 8-bit address. With these values both 64-byte windows fill the top half of the address space. The bench can therefore reach every mailbox index, the edges between the windows, and the addresses below them. A behavioural model of sixteen integers is updated from each bus operation, and `pend_o` and `rdata_o` are compared with it on every cycle. Directed set, clear and read sequences run first, followed by a long run of random operations across all 256 addresses.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_SET  = 2'd1,
    WIN_CLR  = 2'd2
  } win_e;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int N_MBOX   = 16,
  parameter int SET_BASE = 'h80,
  parameter int CLR_BASE = 'hC0
) (
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  output logic [N_MBOX-1:0]         set_hit_o,
  output logic [N_MBOX-1:0]         clr_hit_o,
  output logic                      rd_clr_o,
  output logic [$clog2(N_MBOX)-1:0] rd_idx_o
);
  localparam int IDX_W    = $clog2(N_MBOX);
  localparam int WIN_BITS = IDX_W + 2;
  localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_BASE);
  localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_BASE);

  win_e             win;
  logic [IDX_W-1:0] idx;
  logic             aligned;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign idx     = addr_i[WIN_BITS-1:2];

  always_comb begin
    win = WIN_NONE;
    if (aligned && addr_i[ADDR_W-1:WIN_BITS] == SET_A[ADDR_W-1:WIN_BITS]) win = WIN_SET;
    else if (aligned && addr_i[ADDR_W-1:WIN_BITS] == CLR_A[ADDR_W-1:WIN_BITS]) win = WIN_CLR;
  end

  for (genvar i = 0; i < N_MBOX; i++) begin : g_hit
    assign set_hit_o[i] = req_i && we_i && (win == WIN_SET) && (idx == IDX_W'(i));
    assign clr_hit_o[i] = req_i && we_i && (win == WIN_CLR) && (idx == IDX_W'(i));
  end

  assign rd_clr_o = req_i && !we_i && (win == WIN_CLR);
  assign rd_idx_o = idx;
endmodule

// File: rtl/mbox_cell.sv
module mbox_cell #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o,
  output logic              nonempty_o
);
  logic [DATA_W-1:0] set_mask, clr_mask;

  assign set_mask = set_i ? wdata_i : '0;
  assign clr_mask = clr_i ? wdata_i : '0;

  // set takes priority over a clear of the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_mask) | set_mask;
  end

  assign nonempty_o = |q_o;

  AST_SET_ORS_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q_o & $past(wdata_i)) == $past(wdata_i))); // R3
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((q_o & $past(wdata_i)) == '0)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(q_o)); // R8
endmodule

// File: rtl/mbox_rdmux.sv
module mbox_rdmux #(
  parameter int N_MBOX = 16,
  parameter int DATA_W = 32
) (
  input  logic [N_MBOX-1:0][DATA_W-1:0] mb_i,
  input  logic                          rd_i,
  input  logic [$clog2(N_MBOX)-1:0]     idx_i,
  output logic [DATA_W-1:0]             data_o
);
  always_comb begin
    data_o = '0;
    if (rd_i) data_o = mb_i[idx_i];
  end
endmodule

// File: rtl/core_mailbox.sv
module core_mailbox #(
  parameter int NUM_CORES     = 4,
  parameter int MBOX_PER_CORE = 4,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 8,
  parameter int SET_BASE      = 'h80,
  parameter int CLR_BASE      = 'hC0
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                req_i,
  input  logic                                we_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  output logic [DATA_W-1:0]                   rdata_o,
  output logic [NUM_CORES*MBOX_PER_CORE-1:0]  pend_o
);
  localparam int N_MBOX   = NUM_CORES * MBOX_PER_CORE;
  localparam int IDX_W    = $clog2(N_MBOX);
  localparam int WIN_BITS = IDX_W + 2;
  localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_BASE);

  logic [N_MBOX-1:0]             set_hit, clr_hit;
  logic                          rd_clr;
  logic [IDX_W-1:0]              rd_idx;
  logic [N_MBOX-1:0][DATA_W-1:0] mb;
  logic [DATA_W-1:0]             rd_data;

  mbox_decode #(
    .ADDR_W(ADDR_W), .N_MBOX(N_MBOX), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
  ) u_decode (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .set_hit_o(set_hit), .clr_hit_o(clr_hit),
    .rd_clr_o(rd_clr), .rd_idx_o(rd_idx)
  );

  for (genvar i = 0; i < N_MBOX; i++) begin : g_mb
    mbox_cell #(.DATA_W(DATA_W)) u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(set_hit[i]), .clr_i(clr_hit[i]), .wdata_i(wdata_i),
      .q_o(mb[i]), .nonempty_o(pend_o[i])
    );
  end

  mbox_rdmux #(.N_MBOX(N_MBOX), .DATA_W(DATA_W)) u_rdmux (
    .mb_i(mb), .rd_i(rd_clr), .idx_i(rd_idx), .data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_data;
  end

  AST_SET_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[ADDR_W-1:WIN_BITS] == SET_A[ADDR_W-1:WIN_BITS])
      |=> (rdata_o == '0)); // R7
  AST_NO_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (rdata_o == '0)); // R7
endmodule

// File: tb/core_mailbox_bench.sv
module core_mailbox_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] pend_o;

  int unsigned model [16];
  logic [31:0] exp_rdata;
  string       tag;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  core_mailbox u_core_mailbox (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .pend_o(pend_o)
  );

  function automatic logic [15:0] exp_pend();
    logic [15:0] p;
    for (int i = 0; i < 16; i++) p[i] = (model[i] != 0);
    return p;
  endfunction

  task automatic compare();
    checks++;
    if (pend_o !== exp_pend()) begin
      errors++;
      $display("FAIL %s/R5 pend_o actual %h expected %h", tag, pend_o, exp_pend());
    end
    checks++;
    if (rdata_o !== exp_rdata) begin
      errors++;
      $display("FAIL %s rdata_o actual %h expected %h", tag, rdata_o, exp_rdata);
    end
  endtask

  // compares the previous op's result, then drives a new op at negedge
  task automatic op(input bit rq, input bit w, input logic [7:0] a,
                    input logic [31:0] d, input string t);
    int idx;
    @(negedge clk_i);
    compare();
    tag = t;
    req_i = rq; we_i = w; addr_i = a; wdata_i = d;
    idx = (a & 8'h3F) >> 2;
    exp_rdata = '0;
    if (rq && a[1:0] == 2'b00) begin
      if (w) begin
        if (a >= 8'h80 && a < 8'hC0) model[idx] = model[idx] | d;
        else if (a >= 8'hC0) model[idx] = model[idx] & ~d;
      end else if (a >= 8'hC0) exp_rdata = model[idx];
    end
  endtask

  function automatic logic [7:0] sa(int c, int m); return 8'(8'h80 + 16*c + 4*m); endfunction
  function automatic logic [7:0] ca(int c, int m); return 8'(8'hC0 + 16*c + 4*m); endfunction

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 0;
    exp_rdata = '0;
    tag = "R1";
    repeat (3) @(negedge clk_i);
    tag = "R1"; compare();
    rst_ni = 1'b1;
    op(0, 0, 0, 0, "R1");
    // R2: each mailbox reached through its own set/clear address and pend bit
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 4; m++) begin
        op(1, 1, sa(c, m), 32'h1 << (4*c + m), "R2");
        op(1, 0, ca(c, m), 0, "R2");
        op(1, 1, ca(c, m), 32'hFFFF_FFFF, "R2");
      end
    // R3: OR accumulation
    op(1, 1, sa(1, 2), 32'h0000_00F0, "R3");
    op(1, 1, sa(1, 2), 32'h0000_0F00, "R3");
    op(1, 0, ca(1, 2), 0, "R3");
    // R4: partial clear, then lowest-bit acknowledge
    op(1, 1, ca(1, 2), 32'h0000_0030, "R4");
    op(1, 0, ca(1, 2), 0, "R4");
    op(1, 1, ca(1, 2), 32'h0000_0040, "R4");
    op(1, 0, ca(1, 2), 0, "R4");
    // R5: last bit cleared drops the level
    op(1, 1, ca(1, 2), 32'h0000_0F80, "R5");
    op(0, 0, 0, 0, "R5");
    // R9: full word deposit through mailbox 3
    op(1, 1, sa(2, 3), 32'hDEAD_BEEF, "R9");
    op(1, 0, ca(2, 3), 0, "R9");
    op(1, 1, sa(0, 3), 32'h8000_0001, "R9");
    op(1, 0, ca(0, 3), 0, "R9");
    // R7: set-window, outside and unaligned reads return zero
    op(1, 0, sa(2, 3), 0, "R7");
    op(1, 0, 8'h10, 0, "R7");
    op(1, 0, 8'hEE, 0, "R7");
    op(0, 0, ca(2, 3), 0, "R7");
    // R8: ignored writes, then read back the mailboxes they could touch
    op(1, 1, 8'h81, 32'hFFFF_FFFF, "R8");
    op(1, 1, 8'h40, 32'hFFFF_FFFF, "R8");
    op(1, 1, 8'hEF, 32'hFFFF_FFFF, "R8");
    op(1, 1, 8'h7C, 32'hFFFF_FFFF, "R8");
    op(1, 0, ca(0, 0), 0, "R8");
    op(1, 0, ca(3, 3), 0, "R8");
    op(1, 0, ca(2, 3), 0, "R8");
    op(1, 0, ca(0, 3), 0, "R8");
    // R6: random traffic over the whole map
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] a;
      a = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 3) != 0) a[1:0] = 2'b00;
      if ($urandom_range(0, 5) != 0) a[7] = 1'b1;
      op($urandom_range(0, 5) != 0, $urandom_range(0, 1) == 1, a,
         ($urandom_range(0, 1) == 1) ? (32'h1 << $urandom_range(0, 31)) : $urandom(),
         "R6");
    end
    op(0, 0, 0, 0, "R6");
    @(negedge clk_i);
    compare();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule